// File: doc/BRIEF.md
# Next Instruction Address Selector

This block decides which address a 32-bit RISC core with fixed four-byte, word-aligned instructions fetches next. Each cycle the core hands it the address of the current instruction, a few decoded fields (major opcode, function code, the rt selector, the rd field, the 16-bit immediate and the 26-bit jump index), the two register operands of a compare and the target value read for a register-indirect jump. The block evaluates the conditional tests and returns the next fetch address, whether control flow left the sequential path, and, for call forms, the return address together with the register it must be written to.

It is purely combinational, so it sits between decode and fetch without adding a cycle. A parameter selects whether the core runs with a branch delay slot, which moves the return address one instruction further. A register-indirect target with nonzero low bits raises an address-error flag; the block still presents that target and leaves any recovery to the core.

Top module: `npc_unit`

## Requirements
- R1: For any instruction that is not a control transfer, next_pc_o is pc_i+4, taken_o is 0 and link_en_o is 0.
- R2: Opcode 0x04 is taken when rs_val_i equals rt_val_i; opcode 0x05 is taken when they differ.
- R3: Opcode 0x06 is taken when rs_val_i as a signed number is at most zero; opcode 0x07 is taken when it is above zero.
- R4: Opcode 0x01 with rt_sel_i 0 is taken when rs_val_i is signed negative, with rt_sel_i 1 when it is signed non-negative; any other rt_sel_i value is not a control transfer.
- R5: A taken conditional branch sets next_pc_o to pc_i+4 plus the sign-extended immediate shifted left by two, so 0xFFFF lands on pc_i itself.
- R6: Opcodes 0x02 and 0x03 set next_pc_o to bits 31:28 of pc_i+4, then jidx_i, then two zero bits, with taken_o 1; the region bits follow pc_i+4, not pc_i.
- R7: Opcode 0x03 sets link_en_o, link_reg_o to 31 and link_addr_o to pc_i+8 when the delay-slot parameter is 1 (pc_i+4 when it is 0).
- R8: Opcode 0x00 with funct_i 0x08 sets next_pc_o to reg_tgt_i with taken_o 1 and no link.
- R9: Opcode 0x00 with funct_i 0x09 jumps like R8 and links into rd_i, or into register 31 when rd_i is 0.
- R10: addr_err_o is 1 exactly when a register-indirect jump (R8, R9) has reg_tgt_i bits 1:0 nonzero; next_pc_o still equals reg_tgt_i.
- R11: A conditional branch whose test fails gives next_pc_o = pc_i+4 and taken_o 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Address of the current instruction |
| opcode_i | input | 6 | Major opcode field |
| funct_i | input | 6 | Function code for opcode 0 |
| rt_sel_i | input | 5 | rt field, selects the compare-with-zero test for opcode 1 |
| rd_i | input | 5 | rd field, link destination for the register call form |
| imm_i | input | 16 | Branch displacement in words |
| jidx_i | input | 26 | Direct jump word index |
| rs_val_i | input | 32 | First compare operand |
| rt_val_i | input | 32 | Second compare operand |
| reg_tgt_i | input | 32 | Register-indirect jump target |
| next_pc_o | output | 32 | Address to fetch next |
| taken_o | output | 1 | Control flow leaves the sequential path |
| link_en_o | output | 1 | A return address must be written |
| link_addr_o | output | 32 | Return address |
| link_reg_o | output | 5 | Register receiving the return address (0 when no link) |
| addr_err_o | output | 1 | Misaligned register-indirect target |

## Verification
The hardest situation to reach is a direct jump issued from the last word of a 256 MB region, where the region bits of pc_i and of pc_i+4 differ; the stimulus places pc_i at 0x0FFFFFFC so that a wrong choice of upper bits shows up directly in next_pc_o. The signed tests are also driven at their edges, with rs_val_i at zero, minus one and the most negative value, where an unsigned compare or an off-by-one gives the opposite outcome. Every rt_sel_i value outside the two defined tests is checked to fall back to the sequential address.

// File: rtl/npc_pkg.sv
// Shared encodings and types for the next-address selector.
// Assumes the fixed 32-bit instruction layout with a 6-bit major opcode.
package npc_pkg;
    localparam logic [5:0] OP_SPECIAL = 6'h00;
    localparam logic [5:0] OP_ZCMP    = 6'h01;
    localparam logic [5:0] OP_JUMP    = 6'h02;
    localparam logic [5:0] OP_CALL    = 6'h03;
    localparam logic [5:0] OP_BR_EQ   = 6'h04;
    localparam logic [5:0] OP_BR_NE   = 6'h05;
    localparam logic [5:0] OP_BR_LEZ  = 6'h06;
    localparam logic [5:0] OP_BR_GTZ  = 6'h07;

    localparam logic [5:0] FN_REG_JUMP = 6'h08;
    localparam logic [5:0] FN_REG_CALL = 6'h09;

    localparam logic [4:0] ZSEL_NEG    = 5'd0;
    localparam logic [4:0] ZSEL_NONNEG = 5'd1;

    // Where the next address comes from
    typedef enum logic [1:0] {
        SRC_SEQ  = 2'd0,
        SRC_BR   = 2'd1,
        SRC_DIR  = 2'd2,
        SRC_IND  = 2'd3
    } npc_src_e;

    // Decoded flow control for one instruction
    typedef struct packed {
        npc_src_e src;
        logic     link;
        logic     link_to_rd;
    } npc_ctl_t;
endpackage

// File: rtl/npc_addr_gen.sv
// Candidate address generator.
// Produces the sequential address, the post-slot address, the relative
// branch target and the region-relative direct jump target.
// Assumes word-aligned instructions of four bytes.
module npc_addr_gen #(
    parameter int XLEN   = 32,
    parameter int IMM_W  = 16,
    parameter int JIDX_W = 26
) (
    input  logic [XLEN-1:0]   pc_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [JIDX_W-1:0] jidx_i,
    output logic [XLEN-1:0]   seq_o,
    output logic [XLEN-1:0]   seq2_o,
    output logic [XLEN-1:0]   br_tgt_o,
    output logic [XLEN-1:0]   dir_tgt_o
);
    localparam int REGION_W = XLEN - JIDX_W - 2;
    localparam int EXT_W    = XLEN - IMM_W - 2;

    logic [XLEN-1:0] disp;

    // Sequential and post-slot addresses
    always_comb begin
        seq_o  = pc_i + XLEN'(4);
        seq2_o = pc_i + XLEN'(8);
    end

    // Sign-extend the word displacement into a byte offset
    always_comb begin
        disp = {{EXT_W{imm_i[IMM_W-1]}}, imm_i, 2'b00};
    end

    // Relative and region-relative targets, both based on the sequential address
    always_comb begin
        br_tgt_o  = seq_o + disp;
        dir_tgt_o = {seq_o[XLEN-1 -: REGION_W], jidx_i, 2'b00};
    end

    // Branch targets stay word aligned for aligned current addresses
    always_comb begin
        if (pc_i[1:0] == 2'b00) begin
            assert_br_aligned_R5: assert (br_tgt_o[1:0] == 2'b00)
                else $error("branch target misaligned");
        end
    end
endmodule

// File: rtl/npc_branch_cond.sv
// Conditional branch evaluator.
// Recognises the six compare forms from opcode and rt selector and
// reports whether the instruction is a branch and whether its test holds.
// Assumes two's complement operands.
module npc_branch_cond
    import npc_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int REG_W = 5
) (
    input  logic [5:0]       opcode_i,
    input  logic [REG_W-1:0] rt_sel_i,
    input  logic [XLEN-1:0]  rs_val_i,
    input  logic [XLEN-1:0]  rt_val_i,
    output logic             is_branch_o,
    output logic             cond_true_o
);
    logic rs_neg;
    logic rs_zero;
    logic ops_equal;

    // Basic operand facts shared by all tests
    always_comb begin
        rs_neg    = rs_val_i[XLEN-1];
        rs_zero   = (rs_val_i == '0);
        ops_equal = (rs_val_i == rt_val_i);
    end

    // Select the test named by the opcode and selector
    always_comb begin
        is_branch_o = 1'b0;
        cond_true_o = 1'b0;
        unique case (opcode_i)
            OP_BR_EQ:  begin is_branch_o = 1'b1; cond_true_o = ops_equal;          end
            OP_BR_NE:  begin is_branch_o = 1'b1; cond_true_o = !ops_equal;         end
            OP_BR_LEZ: begin is_branch_o = 1'b1; cond_true_o = rs_neg || rs_zero;  end
            OP_BR_GTZ: begin is_branch_o = 1'b1; cond_true_o = !rs_neg && !rs_zero; end
            OP_ZCMP: begin
                if (rt_sel_i == REG_W'(ZSEL_NEG)) begin
                    is_branch_o = 1'b1;
                    cond_true_o = rs_neg;
                end else if (rt_sel_i == REG_W'(ZSEL_NONNEG)) begin
                    is_branch_o = 1'b1;
                    cond_true_o = !rs_neg;
                end
            end
            default: ;
        endcase
    end

    // A test can only hold for an instruction recognised as a branch
    always_comb begin
        assert_cond_in_branch_R4: assert (!cond_true_o || is_branch_o)
            else $error("condition true outside a branch");
    end
endmodule

// File: rtl/npc_decode.sv
// Flow-control decoder.
// Maps opcode and function code to the address source and link behaviour,
// using the branch evaluator's verdict for conditional forms.
module npc_decode
    import npc_pkg::*;
(
    input  logic [5:0] opcode_i,
    input  logic [5:0] funct_i,
    input  logic       is_branch_i,
    input  logic       cond_true_i,
    output npc_ctl_t   ctl_o
);
    // Choose the source of the next address and the link form
    always_comb begin
        ctl_o = '{src: SRC_SEQ, link: 1'b0, link_to_rd: 1'b0};
        if (is_branch_i) begin
            if (cond_true_i) ctl_o.src = SRC_BR;
        end else begin
            unique case (opcode_i)
                OP_JUMP: ctl_o.src = SRC_DIR;
                OP_CALL: begin
                    ctl_o.src  = SRC_DIR;
                    ctl_o.link = 1'b1;
                end
                OP_SPECIAL: begin
                    if (funct_i == FN_REG_JUMP) begin
                        ctl_o.src = SRC_IND;
                    end else if (funct_i == FN_REG_CALL) begin
                        ctl_o.src        = SRC_IND;
                        ctl_o.link       = 1'b1;
                        ctl_o.link_to_rd = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Linking happens only with an unconditional jump source
    always_comb begin
        assert_link_is_jump_R7: assert (!ctl_o.link || ctl_o.src == SRC_DIR || ctl_o.src == SRC_IND)
            else $error("link without a jump");
    end
endmodule

// File: rtl/npc_unit.sv
// Next instruction address selector (top).
// Combinational: forms candidate addresses, evaluates the branch test,
// decodes the flow form, and selects the next fetch address, the link
// address and its destination register. Flags misaligned indirect targets.
// DELAY_SLOT=1 places the return address after the delay-slot instruction.
module npc_unit
    import npc_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int IMM_W      = 16,
    parameter int JIDX_W     = 26,
    parameter int REG_W      = 5,
    parameter int LINK_REG   = 31,
    parameter bit DELAY_SLOT = 1'b1
) (
    input  logic [XLEN-1:0]   pc_i,
    input  logic [5:0]        opcode_i,
    input  logic [5:0]        funct_i,
    input  logic [REG_W-1:0]  rt_sel_i,
    input  logic [REG_W-1:0]  rd_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [JIDX_W-1:0] jidx_i,
    input  logic [XLEN-1:0]   rs_val_i,
    input  logic [XLEN-1:0]   rt_val_i,
    input  logic [XLEN-1:0]   reg_tgt_i,
    output logic [XLEN-1:0]   next_pc_o,
    output logic              taken_o,
    output logic              link_en_o,
    output logic [XLEN-1:0]   link_addr_o,
    output logic [REG_W-1:0]  link_reg_o,
    output logic              addr_err_o
);
    logic [XLEN-1:0] seq, seq2, br_tgt, dir_tgt, ret_addr;
    logic            is_branch, cond_true;
    npc_ctl_t        ctl;

    npc_addr_gen #(.XLEN(XLEN), .IMM_W(IMM_W), .JIDX_W(JIDX_W)) u_addr (
        .pc_i      (pc_i),
        .imm_i     (imm_i),
        .jidx_i    (jidx_i),
        .seq_o     (seq),
        .seq2_o    (seq2),
        .br_tgt_o  (br_tgt),
        .dir_tgt_o (dir_tgt)
    );

    npc_branch_cond #(.XLEN(XLEN), .REG_W(REG_W)) u_cond (
        .opcode_i    (opcode_i),
        .rt_sel_i    (rt_sel_i),
        .rs_val_i    (rs_val_i),
        .rt_val_i    (rt_val_i),
        .is_branch_o (is_branch),
        .cond_true_o (cond_true)
    );

    npc_decode u_dec (
        .opcode_i    (opcode_i),
        .funct_i     (funct_i),
        .is_branch_i (is_branch),
        .cond_true_i (cond_true),
        .ctl_o       (ctl)
    );

    // Return address depends on the pipeline's delay-slot convention
    generate
        if (DELAY_SLOT) begin : g_slot
            assign ret_addr = seq2;
        end else begin : g_noslot
            assign ret_addr = seq;
        end
    endgenerate

    // Select the next fetch address
    always_comb begin
        unique case (ctl.src)
            SRC_BR:  next_pc_o = br_tgt;
            SRC_DIR: next_pc_o = dir_tgt;
            SRC_IND: next_pc_o = reg_tgt_i;
            default: next_pc_o = seq;
        endcase
        taken_o = (ctl.src != SRC_SEQ);
    end

    // Link outputs and the destination register
    always_comb begin
        link_en_o   = ctl.link;
        link_addr_o = ret_addr;
        link_reg_o  = '0;
        if (ctl.link) begin
            if (ctl.link_to_rd && rd_i != '0) link_reg_o = rd_i;
            else                               link_reg_o = REG_W'(LINK_REG);
        end
    end

    // Misaligned indirect target detection
    always_comb begin
        addr_err_o = (ctl.src == SRC_IND) && (reg_tgt_i[1:0] != 2'b00);
    end

    // Untaken flow always continues sequentially
    always_comb begin
        if (!taken_o) begin
            assert_untaken_seq_R1: assert (next_pc_o == pc_i + XLEN'(4) && !link_en_o)
                else $error("untaken flow not sequential");
        end
    end

    // Only an indirect jump can raise the address error
    always_comb begin
        if (addr_err_o) begin
            assert_err_only_ind_R10: assert (opcode_i == OP_SPECIAL && taken_o && next_pc_o == reg_tgt_i)
                else $error("address error outside indirect jump");
        end
    end

    // A link always names a nonzero destination register
    always_comb begin
        if (link_en_o) begin
            assert_link_dest_R9: assert (link_reg_o != '0 && taken_o)
                else $error("link to register zero");
        end
    end

    // Direct jumps stay inside the region of the sequential address
    always_comb begin
        if (taken_o && (opcode_i == OP_JUMP || opcode_i == OP_CALL)) begin
            assert_jump_region_R6: assert (next_pc_o[XLEN-1 -: 4] == seq[XLEN-1 -: 4] && next_pc_o[1:0] == 2'b00)
                else $error("direct jump left its region");
        end
    end
endmodule

// File: tb/test_npc_unit.sv
// Directed bench for the next instruction address selector.
module test_npc_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [31:0] pc, rs, rt, tgt;
    logic [5:0]  op, fn;
    logic [4:0]  rtsel, rd;
    logic [15:0] imm;
    logic [25:0] jidx;
    logic [31:0] next_pc, link_addr;
    logic        taken, link_en, addr_err;
    logic [4:0]  link_reg;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    npc_unit i_npc_unit (
        .pc_i(pc), .opcode_i(op), .funct_i(fn), .rt_sel_i(rtsel), .rd_i(rd),
        .imm_i(imm), .jidx_i(jidx), .rs_val_i(rs), .rt_val_i(rt), .reg_tgt_i(tgt),
        .next_pc_o(next_pc), .taken_o(taken), .link_en_o(link_en),
        .link_addr_o(link_addr), .link_reg_o(link_reg), .addr_err_o(addr_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] p, input logic [5:0] o, input logic [5:0] f,
                         input logic [4:0] s, input logic [4:0] d, input logic [15:0] i,
                         input logic [25:0] j, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] t);
        @(negedge clk);
        pc = p; op = o; fn = f; rtsel = s; rd = d; imm = i; jidx = j; rs = a; rt = b; tgt = t;
        #2;
    endtask

    task automatic expect_seq(input string req, input logic [31:0] p);
        chk(req, next_pc, p + 32'd4);
        chk(req, {31'd0, taken}, 32'd0);
        chk(req, {31'd0, link_en}, 32'd0);
    endtask

    // Idle inputs: opcode 0 funct 0 is not a control transfer (R1)
    task automatic t_idle();
        apply(32'h0, 6'h00, 6'h00, 5'd0, 5'd0, 16'h0, 26'h0, 32'h0, 32'h0, 32'h0);
        expect_seq("R1 idle", 32'h0);
        chk("R1 idle err", {31'd0, addr_err}, 32'd0);
        apply(32'h0040_0100, 6'h08, 6'h00, 5'd3, 5'd4, 16'h0010, 26'h3, 32'h5, 32'h5, 32'h2);
        expect_seq("R1 arith op", 32'h0040_0100);
        apply(32'h0040_0100, 6'h00, 6'h20, 5'd3, 5'd4, 16'h0010, 26'h3, 32'h5, 32'h5, 32'h2);
        expect_seq("R1 funct add", 32'h0040_0100);
        chk("R10 no err on non-jump", {31'd0, addr_err}, 32'd0);
    endtask

    // Equality branches (R2, R5, R11)
    task automatic t_eq_ne();
        apply(32'h0000_1000, 6'h04, 6'h0, 5'd0, 5'd0, 16'h0003, 26'h0, 32'h77, 32'h77, 32'h0);
        chk("R2 beq taken pc", next_pc, 32'h0000_1010);
        chk("R2 beq taken flag", {31'd0, taken}, 32'd1);
        apply(32'h0000_1000, 6'h04, 6'h0, 5'd0, 5'd0, 16'h0003, 26'h0, 32'h77, 32'h78, 32'h0);
        expect_seq("R11 beq not taken", 32'h0000_1000);
        apply(32'h0000_1000, 6'h05, 6'h0, 5'd0, 5'd0, 16'hFFFF, 26'h0, 32'h1, 32'h2, 32'h0);
        chk("R5 bne back to self", next_pc, 32'h0000_1000);
        apply(32'h0000_1000, 6'h05, 6'h0, 5'd0, 5'd0, 16'hFFFF, 26'h0, 32'h2, 32'h2, 32'h0);
        expect_seq("R11 bne not taken", 32'h0000_1000);
        apply(32'h0001_0000, 6'h04, 6'h0, 5'd0, 5'd0, 16'h8000, 26'h0, 32'h0, 32'h0, 32'h3);
        chk("R5 most negative offset", next_pc, 32'h0001_0004 - 32'h0002_0000);
        chk("R10 no err on branch", {31'd0, addr_err}, 32'd0);
        apply(32'h0001_0000, 6'h04, 6'h0, 5'd0, 5'd0, 16'h7FFF, 26'h0, 32'h0, 32'h0, 32'h0);
        chk("R5 most positive offset", next_pc, 32'h0001_0004 + 32'h0001_FFFC);
    endtask

    // Signed compares against zero for opcodes 6 and 7 (R3)
    task automatic t_lez_gtz();
        logic [31:0] vals [4] = '{32'h0, 32'hFFFF_FFFF, 32'h1, 32'h8000_0000};
        for (int k = 0; k < 4; k++) begin
            logic le;
            le = ($signed(vals[k]) <= 0);
            apply(32'h0000_2000, 6'h06, 6'h0, 5'd0, 5'd0, 16'h0004, 26'h0, vals[k], 32'h0, 32'h0);
            chk("R3 lez", next_pc, le ? 32'h0000_2014 : 32'h0000_2004);
            chk("R3 lez flag", {31'd0, taken}, {31'd0, le});
            apply(32'h0000_2000, 6'h07, 6'h0, 5'd0, 5'd0, 16'h0004, 26'h0, vals[k], 32'h0, 32'h0);
            chk("R3 gtz flag", {31'd0, taken}, {31'd0, !le});
        end
    endtask

    // Compare-with-zero group selected by rt (R4)
    task automatic t_zcmp();
        apply(32'h0000_3000, 6'h01, 6'h0, 5'd0, 5'd0, 16'h0002, 26'h0, 32'h8000_0000, 32'h0, 32'h0);
        chk("R4 ltz negative", next_pc, 32'h0000_300C);
        apply(32'h0000_3000, 6'h01, 6'h0, 5'd0, 5'd0, 16'h0002, 26'h0, 32'h0, 32'h0, 32'h0);
        expect_seq("R4 ltz zero", 32'h0000_3000);
        apply(32'h0000_3000, 6'h01, 6'h0, 5'd1, 5'd0, 16'h0002, 26'h0, 32'h0, 32'h0, 32'h0);
        chk("R4 gez zero", next_pc, 32'h0000_300C);
        apply(32'h0000_3000, 6'h01, 6'h0, 5'd1, 5'd0, 16'h0002, 26'h0, 32'hFFFF_FFFF, 32'h0, 32'h0);
        expect_seq("R4 gez negative", 32'h0000_3000);
        for (int s = 2; s < 32; s++) begin
            apply(32'h0000_3000, 6'h01, 6'h0, 5'(s), 5'd0, 16'h0002, 26'h0, 32'h0, 32'h0, 32'h0);
            chk("R4 undefined selector", next_pc, 32'h0000_3004);
            chk("R4 undefined selector flag", {31'd0, taken}, 32'd0);
        end
    endtask

    // Direct jumps and the region bits (R6, R7)
    task automatic t_jump();
        apply(32'h0040_0000, 6'h02, 6'h0, 5'd0, 5'd0, 16'h0, 26'h000_001E, 32'h0, 32'h0, 32'h0);
        chk("R6 jump target", next_pc, 32'h0000_0078);
        chk("R6 jump flag", {31'd0, taken}, 32'd1);
        chk("R6 jump no link", {31'd0, link_en}, 32'd0);
        apply(32'h0FFF_FFFC, 6'h02, 6'h0, 5'd0, 5'd0, 16'h0, 26'h000_0010, 32'h0, 32'h0, 32'h0);
        chk("R6 region from pc+4", next_pc, 32'h1000_0040);
        apply(32'hA000_0100, 6'h03, 6'h0, 5'd0, 5'd0, 16'h0, 26'h3FF_FFFF, 32'h0, 32'h0, 32'h0);
        chk("R6 call target", next_pc, 32'hAFFF_FFFC);
        chk("R7 call link en", {31'd0, link_en}, 32'd1);
        chk("R7 call link reg", {27'd0, link_reg}, 32'd31);
        chk("R7 call link addr", link_addr, 32'hA000_0108);
    endtask

    // Register-indirect forms and misalignment (R8, R9, R10)
    task automatic t_indirect();
        apply(32'h0000_4000, 6'h00, 6'h08, 5'd0, 5'd7, 16'h0, 26'h0, 32'h0, 32'h0, 32'h1234_5678);
        chk("R8 jr target", next_pc, 32'h1234_5678);
        chk("R8 jr flag", {31'd0, taken}, 32'd1);
        chk("R8 jr no link", {31'd0, link_en}, 32'd0);
        chk("R10 aligned no err", {31'd0, addr_err}, 32'd0);
        apply(32'h0000_4000, 6'h00, 6'h09, 5'd0, 5'd5, 16'h0, 26'h0, 32'h0, 32'h0, 32'h0000_8000);
        chk("R9 jalr target", next_pc, 32'h0000_8000);
        chk("R9 jalr rd", {27'd0, link_reg}, 32'd5);
        chk("R9 jalr addr", link_addr, 32'h0000_4008);
        apply(32'h0000_4000, 6'h00, 6'h09, 5'd0, 5'd0, 16'h0, 26'h0, 32'h0, 32'h0, 32'h0000_8000);
        chk("R9 jalr default reg", {27'd0, link_reg}, 32'd31);
        for (int m = 1; m < 4; m++) begin
            apply(32'h0000_4000, 6'h00, (m == 2) ? 6'h09 : 6'h08, 5'd0, 5'd0, 16'h0, 26'h0,
                  32'h0, 32'h0, 32'h0000_9000 | 32'(m));
            chk("R10 misaligned err", {31'd0, addr_err}, 32'd1);
            chk("R10 target kept", next_pc, 32'h0000_9000 | 32'(m));
        end
        apply(32'h0000_4000, 6'h04, 6'h08, 5'd0, 5'd0, 16'h1, 26'h0, 32'h0, 32'h0, 32'h0000_9001);
        chk("R10 branch ignores target", {31'd0, addr_err}, 32'd0);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        pc = '0; op = '0; fn = '0; rtsel = '0; rd = '0; imm = '0; jidx = '0;
        rs = '0; rt = '0; tgt = '0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_eq_ne();
        t_lez_gtz();
        t_zcmp();
        t_jump();
        t_indirect();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule